// File: doc/BRIEF.md
# Shadowed RAM Store/Recall Controller

This block is a byte-wide static RAM with a second nonvolatile-style array behind it that holds one byte per RAM byte. A host reaches the RAM through four active-low strobes: chip select, output enable, write enable and a nonvolatile-enable line. The strobes are sampled on the clock. Depending on their levels the block performs a RAM read, a RAM write or a host-initiated recall, which copies the whole shadow array into RAM.

A separate command or power-fail block requests a store through a one-bit input. A store copies the whole RAM into the shadow array. The output-enable strobe, when low, vetoes that request. Both transfers move one address per cycle, starting at address 0 and ending at the top address. Each transfer keeps `busy` high for a parameterized number of cycles. The recall time is short and the store time is long. While `busy` is high the host port is shut out.

The data bus is modelled as a driven value plus an output-enable flag. A pad ring turns these into a tri-state pin.

Top module: `shadow_ram_ctrl`

## Requirements
- R1: While idle, with ce_n=0, oe_n=0, we_n=1 and ne_n=1, data_oe is 1 and data_out equals the RAM byte at addr, combinationally.
- R2: While idle, RAM[addr] takes data_in at the first clock edge of ce_n=0, we_n=0, ne_n=1. If that combination is held over further edges, nothing more is written, so a later change of data_in has no effect.
- R3: data_oe is 0 whenever ce_n=1, oe_n=1 or ne_n=0.
- R4: While idle, the first clock edge of ne_n=0, oe_n=0, ce_n=0, we_n=1 starts a recall. busy rises after that edge, and the shadow array is copied into all RAM addresses.
- R5: While idle, an edge with store_req=1 and oe_n=1 starts a store. busy rises after that edge, and the whole RAM is copied into the shadow array.
- R6: A store request seen while oe_n=0 has no effect. busy stays 0 and no store takes place.
- R7: While busy=1, data_oe is 0. RAM write strobes are ignored, and so are further store and recall requests.
- R8: busy stays high for exactly STORE_CYCLES clock edges for a store and exactly RECALL_CYCLES edges for a recall, then returns to 0.
- R9: During reset, busy is 0 and data_oe is 0 with the strobes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low; vetoes store |
| we_n | input | 1 | Write enable, active low |
| ne_n | input | 1 | Nonvolatile enable, active low; selects recall |
| addr | input | ADDR_W | Byte address |
| data_in | input | DATA_W | Write data from the bus |
| data_out | output | DATA_W | Read data towards the bus |
| data_oe | output | 1 | Bus drive enable; 0 means high impedance |
| store_req | input | 1 | Store request from the command/power-fail block |
| busy | output | 1 | A store or recall is in progress |

## Verification
A wrong transfer counter shows up at the ports in two ways. busy may fall on the wrong edge. A copy may also skip an address or write the wrong one, which a full read-back after a store-then-recall round trip exposes within one array pass. A stuck edge detector shows as repeated writes while a write strobe is held, or as a missing recall, at the next read of that byte. A faulty busy gate becomes visible at once, because a read during a transfer then drives the bus, or a write made during a store survives it.

// File: rtl/shadow_ram_pkg.sv
package shadow_ram_pkg;
  typedef enum logic [1:0] {
    XFER_IDLE   = 2'd0,
    XFER_STORE  = 2'd1,
    XFER_RECALL = 2'd2
  } xfer_e;
endpackage

// File: rtl/shadow_strobe_dec.sv
module shadow_strobe_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic ne_n,
  input  logic store_req,
  input  logic busy,
  output logic rd_act,
  output logic wr_go,
  output logic rcl_go,
  output logic st_go
);
  logic wr_lvl, rcl_lvl;
  logic wr_prev_q, rcl_prev_q;

  assign wr_lvl  = !ce_n && !we_n && ne_n;
  assign rcl_lvl = !ce_n && !oe_n && !ne_n && we_n;
  assign rd_act  = !busy && !ce_n && !oe_n && we_n && ne_n;
  assign st_go   = !busy && store_req && oe_n;
  assign rcl_go  = !busy && rcl_lvl && !rcl_prev_q;
  // a store starting on the same edge takes precedence over a write
  assign wr_go   = !busy && wr_lvl && !wr_prev_q && !st_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q  <= 1'b0;
      rcl_prev_q <= 1'b0;
    end else begin
      wr_prev_q  <= wr_lvl;
      rcl_prev_q <= rcl_lvl;
    end
  end
endmodule

// File: rtl/shadow_xfer_seq.sv
module shadow_xfer_seq
  import shadow_ram_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int STORE_CYCLES  = 50000,
  parameter int RECALL_CYCLES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_store,
  input  logic              start_recall,
  output logic              busy,
  output logic              copy_en,
  output logic              copy_store,
  output logic [ADDR_W-1:0] copy_idx
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int LEN_MAX = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CW      = $clog2(LEN_MAX + 1) > ADDR_W ? $clog2(LEN_MAX + 1) : ADDR_W + 1;
  localparam logic [CW-1:0] STORE_LAST  = CW'(STORE_CYCLES - 1);
  localparam logic [CW-1:0] RECALL_LAST = CW'(RECALL_CYCLES - 1);
  localparam logic [CW-1:0] DEPTH_C     = CW'(DEPTH);

  xfer_e         mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last;
  logic          cnt_en;

  assign busy       = (mode_q != XFER_IDLE);
  assign last       = (mode_q == XFER_STORE) ? STORE_LAST : RECALL_LAST;
  assign cnt_en     = busy || start_store || start_recall;
  assign copy_en    = busy && (cnt_q < DEPTH_C);
  assign copy_store = (mode_q == XFER_STORE);
  assign copy_idx   = cnt_q[ADDR_W-1:0];

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    case (mode_q)
      XFER_IDLE: begin
        cnt_d = '0;
        if (start_store)       mode_d = XFER_STORE;
        else if (start_recall) mode_d = XFER_RECALL;
      end
      default: begin
        if (cnt_q == last) begin
          mode_d = XFER_IDLE;
          cnt_d  = '0;
        end else begin
          cnt_d  = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= XFER_IDLE;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/shadow_mem.sv
module shadow_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              copy_en,
  input  logic              copy_store,
  input  logic [ADDR_W-1:0] copy_idx
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram    [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];

  assign host_rdata = ram[host_addr];

  always_ff @(posedge clk) begin
    if (copy_en && copy_store) shadow[copy_idx] <= ram[copy_idx];
  end

  always_ff @(posedge clk) begin
    if (copy_en && !copy_store)  ram[copy_idx]  <= shadow[copy_idx];
    else if (host_we)            ram[host_addr] <= host_wdata;
  end
endmodule

// File: rtl/shadow_ram_ctrl.sv
module shadow_ram_ctrl #(
  parameter int ADDR_W        = 11,
  parameter int DATA_W        = 8,
  parameter int STORE_CYCLES  = 50000,
  parameter int RECALL_CYCLES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              ne_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic              store_req,
  output logic              busy
);
  logic              rd_act, wr_go, rcl_go, st_go;
  logic              copy_en, copy_store;
  logic [ADDR_W-1:0] copy_idx;
  logic [DATA_W-1:0] rdata;

  shadow_strobe_dec i_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .ne_n(ne_n),
    .store_req(store_req), .busy(busy),
    .rd_act(rd_act), .wr_go(wr_go), .rcl_go(rcl_go), .st_go(st_go)
  );

  shadow_xfer_seq #(
    .ADDR_W(ADDR_W), .STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .start_store(st_go), .start_recall(rcl_go),
    .busy(busy), .copy_en(copy_en), .copy_store(copy_store), .copy_idx(copy_idx)
  );

  shadow_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk(clk), .host_we(wr_go), .host_addr(addr), .host_wdata(data_in),
    .host_rdata(rdata), .copy_en(copy_en), .copy_store(copy_store), .copy_idx(copy_idx)
  );

  assign data_oe  = rd_act;
  assign data_out = rd_act ? rdata : '0;
endmodule

// File: rtl/shadow_ram_chk.sv
module shadow_ram_chk #(
  parameter int STORE_CYCLES  = 50000,
  parameter int RECALL_CYCLES = 2048
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic ne_n,
  input logic store_req,
  input logic data_oe,
  input logic busy
);
  logic rcl_lvl, rcl_prev_q, kind_store_q;
  int   run_q;

  assign rcl_lvl = !ce_n && !oe_n && !ne_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcl_prev_q   <= 1'b0;
      kind_store_q <= 1'b0;
      run_q        <= 0;
    end else begin
      rcl_prev_q <= rcl_lvl;
      if (!busy) kind_store_q <= store_req && oe_n;
      run_q <= busy ? run_q + 1 : 0;
    end
  end

  a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ce_n && !oe_n && we_n && ne_n) |-> data_oe);
  a_r3_bus_float: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !ne_n) |-> !data_oe);
  a_r4_recall_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rcl_lvl && !rcl_prev_q) |=> busy);
  a_r5_store_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && store_req && oe_n) |=> busy);
  a_r6_store_veto: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && store_req && !oe_n && ne_n) |=> !busy);
  a_r7_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !data_oe);
  a_r8_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == (kind_store_q ? STORE_CYCLES : RECALL_CYCLES)));
endmodule

bind shadow_ram_ctrl shadow_ram_chk #(
  .STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .ne_n(ne_n),
  .store_req(store_req), .data_oe(data_oe), .busy(busy)
);

// File: tb/test_shadow_ram_ctrl.sv
module test_shadow_ram_ctrl;
  localparam int AW    = 5;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int STC   = 40;
  localparam int RCC   = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ne_n = 1'b1, store_req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] data_out;
  logic data_oe, busy;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic [DW-1:0] ram_m [DEPTH];
  logic [DW-1:0] sh_m  [DEPTH];

  always #5 clk = ~clk;

  shadow_ram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYCLES(STC), .RECALL_CYCLES(RCC))
  i_shadow_ram_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .ne_n(ne_n),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .store_req(store_req), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_read(input int a);
    return ram_m[a];
  endfunction

  task automatic idle_strobes();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; ne_n = 1'b1;
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = AW'(a); data_in = d; ce_n = 0; we_n = 0; oe_n = 1; ne_n = 1;
    @(negedge clk);
    idle_strobes();
    ram_m[a] = d;
  endtask

  task automatic do_read(input int a, input string req);
    @(negedge clk);
    addr = AW'(a); ce_n = 0; oe_n = 0; we_n = 1; ne_n = 1;
    #1;
    chk(data_oe === 1'b1 && data_out === expect_read(a), req, {data_oe, data_out},
        {1'b1, expect_read(a)});
    idle_strobes();
  endtask

  // counts negedges with busy high after the start edge
  task automatic count_busy(output int n, input bit poke);
    n = 0;
    while (busy === 1'b1 && n < 1000) begin
      n++;
      if (poke && n == 2) begin addr = 3; data_in = ~ram_m[3]; ce_n = 0; we_n = 0; end
      if (poke && n == 4) idle_strobes();
      if (poke && n == 6) begin
        ce_n = 0; oe_n = 0; #1;
        chk(data_oe === 1'b0, "R7 read while busy", data_oe, 0);
      end
      if (poke && n == 8) begin
        idle_strobes(); store_req = 1;
      end
      if (poke && n == 9) store_req = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R9 busy in reset", busy, 0);
    chk(data_oe === 1'b0, "R9 data_oe in reset", data_oe, 0);
    rst_n = 1'b1;

    for (int a = 0; a < DEPTH; a++) do_write(a, DW'($urandom));
    for (int a = 0; a < DEPTH; a++) do_read(a, "R1 readback");

    // R2: held write strobe writes once
    @(negedge clk);
    addr = 7; data_in = 8'h5A; ce_n = 0; we_n = 0;
    @(negedge clk); data_in = 8'hC3;
    @(negedge clk); data_in = 8'h0F;
    @(negedge clk); idle_strobes(); ram_m[7] = 8'h5A;
    do_read(7, "R2 held write");

    // R3: float cases
    @(negedge clk); ce_n = 1; oe_n = 0; #1;
    chk(data_oe === 1'b0, "R3 ce_n high", data_oe, 0);
    ce_n = 0; oe_n = 1; #1;
    chk(data_oe === 1'b0, "R3 oe_n high", data_oe, 0);
    oe_n = 1; ne_n = 0; #1;
    chk(data_oe === 1'b0, "R3 ne_n low", data_oe, 0);
    idle_strobes();

    // R6: store vetoed by oe_n low
    @(negedge clk); store_req = 1; oe_n = 0;
    @(negedge clk); store_req = 0; idle_strobes();
    chk(busy === 1'b0, "R6 store veto", busy, 0);

    // R5/R8/R7: store with host traffic during busy
    @(negedge clk); store_req = 1;
    @(negedge clk); store_req = 0;
    chk(busy === 1'b1, "R5 store starts", busy, 1);
    for (int a = 0; a < DEPTH; a++) sh_m[a] = ram_m[a];
    count_busy(n, 1'b1);
    chk(n == STC, "R8 store length", n, STC);
    idle_strobes();
    do_read(3, "R7 write ignored while busy");

    // overwrite RAM, then recall (R4)
    for (int a = 0; a < DEPTH; a++) do_write(a, DW'($urandom));
    @(negedge clk); ce_n = 0; oe_n = 0; ne_n = 0; we_n = 1; #1;
    chk(data_oe === 1'b0, "R3 recall strobes float", data_oe, 0);
    @(negedge clk); idle_strobes();
    chk(busy === 1'b1, "R4 recall starts", busy, 1);
    count_busy(n, 1'b0);
    chk(n == RCC, "R8 recall length", n, RCC);
    for (int a = 0; a < DEPTH; a++) ram_m[a] = sh_m[a];
    for (int a = 0; a < DEPTH; a++) do_read(a, "R4 recalled data");

    // R6: vetoed store left shadow untouched; recall confirms
    for (int a = 0; a < DEPTH; a++) do_write(a, DW'($urandom));
    @(negedge clk); store_req = 1; oe_n = 0;
    @(negedge clk); store_req = 0; idle_strobes();
    @(negedge clk); ce_n = 0; oe_n = 0; ne_n = 0;
    @(negedge clk); idle_strobes();
    count_busy(n, 1'b0);
    for (int a = 0; a < DEPTH; a++) ram_m[a] = sh_m[a];
    do_read(0, "R6 shadow unchanged low");
    do_read(DEPTH - 1, "R6 shadow unchanged high");

    // random mix of reads, writes and idle strobes
    for (int i = 0; i < 300; i++) begin
      int op = int'($urandom % 3);
      int a  = int'($urandom % DEPTH);
      if (op == 0) do_write(a, DW'($urandom));
      else if (op == 1) do_read(a, "R1 random read");
      else begin
        @(negedge clk); ce_n = 1; oe_n = $urandom; we_n = $urandom; ne_n = $urandom; #1;
        chk(data_oe === 1'b0, "R3 random float", data_oe, 0);
        idle_strobes();
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule